// File: doc/BRIEF.md
# Strobe-Driven FIFO with Read Rewind

This block is a first-in first-out buffer of 512 words, each 9 bits wide (eight data bits plus one bit free for parity or a control marker). It has no address inputs: a write ring pointer and a read ring pointer step through storage on their own. A producer pushes a word by pulsing an active-low write strobe, and a consumer pops a word by pulsing an active-low read strobe. Active-low empty and full flags tell both sides when to hold off.

All three strobes are sampled on a system clock by a two-stage register chain, and each strobe acts on its detected edges. A read takes effect on the falling edge of the read strobe. The popped word is presented on the data output, with a valid indication, for as long as the strobe stays low. A write is accepted on the falling edge of the write strobe, and the input word is stored when the strobe rises again. The data interface is strobe-paced rather than valid/ready. Back-pressure is expressed only through the flags, and a strobe given against a flag is dropped.

A rewind input, pulsed low, sends the read pointer back to location zero so that the words written since reset can be read out again. The write pointer is not moved. Rewind is honoured only while both strobes are idle and while fewer than 512 writes have completed since reset. A sticky error output records every strobe or rewind that was refused.

Top module: `sfifo_strobe`

## Requirements
- R1: While and after reset (rst_n low), empty_n is 0, full_n is 1, dout_vld is 0 and err is 0.
- R2: Words leave in the order they were written, with all 9 bits intact.
- R3: A write stores the value on din at the rising edge of wr_n, even if din changed while wr_n was low.
- R4: empty_n goes to 1 after the first completed write and returns to 0 when a read leaves no stored word; empty_n and full_n are never both 0.
- R5: full_n goes to 0 once 512 words are held. A write started while full_n is 0 stores nothing, keeps full_n at 0 and sets err, and all 512 held words still read back in order.
- R6: A read started while empty_n is 0 leaves dout_vld at 0, moves no pointer and sets err.
- R7: full_n returns to 1 after a completed read.
- R8: A legal low pulse on rewind_n makes the next read return the first word written since reset. Later reads replay the stored words in order, and the next write lands after the last word written before the rewind.
- R9: A rewind pulse while rd_n or wr_n is low has no effect on the read order and sets err.
- R10: A rewind pulse after 512 or more writes since reset has no effect on the read order and sets err.
- R11: dout_vld is 1 only after an accepted read edge and until rd_n returns high. Each low period of rd_n pops exactly one word.
- R12: err, once set, stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low asynchronous reset; both pointers go to zero |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| rewind_n | input | 1 | Active-low pulse that returns the read pointer to zero |
| din | input | 9 | Word to store, taken at the rising edge of wr_n |
| dout | output | 9 | Popped word; zero while dout_vld is 0 |
| dout_vld | output | 1 | High while a popped word is being presented |
| empty_n | output | 1 | Low when no word is held |
| full_n | output | 1 | Low when 512 words are held |
| err | output | 1 | Sticky flag for a refused read, write or rewind |

## Verification
The assertions assume that every strobe level lasts at least two clock cycles, so the sampling chain sees each edge once. They also assume that all strobes are high during reset. Given that, they assume the flags can only leave their asserted state through the opposite strobe or a legal rewind. The bench changes inputs only on falling clock edges and holds each strobe level for three cycles. It keeps din steady across the rising edge of wr_n. It creates illegal situations only through the flags and the rewind conditions that the requirements define, never through glitch-length pulses.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // positions of the strobes inside the sampled strobe vector
  localparam int STB_RD = 0;
  localparam int STB_WR = 1;
  localparam int STB_RW = 2;
  localparam int STB_N  = 3;
endpackage

// File: rtl/sfifo_sync.sv
module sfifo_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q1,
  output logic [N-1:0] q2
);
  // two sampling stages per strobe; idle level (high) after reset
  for (genvar i = 0; i < N; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q1[i] <= 1'b1;
        q2[i] <= 1'b1;
      end else begin
        q1[i] <= d[i];
        q2[i] <= q1[i];
      end
    end
  end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_en,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
    if (rd_en) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int CW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fall,
  input  logic          rd_rise,
  input  logic          wr_fall,
  input  logic          wr_rise,
  input  logic          rw_fall,
  input  logic          strobes_idle,
  output logic          rd_en,
  output logic          wr_en,
  output logic          rew_go,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] wptr,
  output logic [CW-1:0] occ,
  output logic          dout_vld,
  output logic          err
);
  localparam logic [CW-1:0] OCC_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_TOP = AW'(DEPTH - 1);

  logic          wr_open;
  logic [CW-1:0] wr_total;
  logic          is_empty, is_full, wr_take, rew_ok, bad;

  assign is_empty = (occ == '0);
  assign is_full  = (occ == OCC_MAX);
  assign rd_en    = rd_fall && !is_empty;
  assign wr_take  = wr_fall && !is_full;
  assign wr_en    = wr_rise && wr_open;
  assign rew_ok   = strobes_idle && !wr_open && (wr_total < OCC_MAX);
  assign rew_go   = rw_fall && rew_ok;
  assign bad      = (rd_fall && is_empty) || (wr_fall && is_full) || (rw_fall && !rew_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      wptr     <= '0;
      occ      <= '0;
      wr_open  <= 1'b0;
      wr_total <= '0;
      dout_vld <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (wr_take)      wr_open <= 1'b1;
      else if (wr_rise) wr_open <= 1'b0;

      if (rd_en)        dout_vld <= 1'b1;
      else if (rd_rise) dout_vld <= 1'b0;

      if (bad) err <= 1'b1;

      if (wr_en) begin
        wptr <= (wptr == PTR_TOP) ? '0 : wptr + 1'b1;
        if (wr_total != OCC_MAX) wr_total <= wr_total + 1'b1;
      end

      if (rew_go) begin
        rptr <= '0;
        occ  <= {{(CW-AW){1'b0}}, wptr};
      end else begin
        if (rd_en) rptr <= (rptr == PTR_TOP) ? '0 : rptr + 1'b1;
        occ <= occ + CW'(wr_en) - CW'(rd_en);
      end
    end
  end
endmodule

// File: rtl/sfifo_strobe.sv
module sfifo_strobe
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             rewind_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_vld,
  output logic             empty_n,
  output logic             full_n,
  output logic             err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [STB_N-1:0] stb_raw, stb_q1, stb_q2;
  logic             rd_fall, rd_rise, wr_fall, wr_rise, rw_fall, strobes_idle;
  logic             rd_en, wr_en, rew_go;
  logic [AW-1:0]    rptr, wptr;
  logic [CW-1:0]    occ;
  logic [WIDTH-1:0] din_q, rdata;

  always_comb begin
    stb_raw         = '1;
    stb_raw[STB_RD] = rd_n;
    stb_raw[STB_WR] = wr_n;
    stb_raw[STB_RW] = rewind_n;
  end

  sfifo_sync #(.N(STB_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(stb_raw), .q1(stb_q1), .q2(stb_q2)
  );

  assign rd_fall      = stb_q2[STB_RD] & ~stb_q1[STB_RD];
  assign rd_rise      = ~stb_q2[STB_RD] & stb_q1[STB_RD];
  assign wr_fall      = stb_q2[STB_WR] & ~stb_q1[STB_WR];
  assign wr_rise      = ~stb_q2[STB_WR] & stb_q1[STB_WR];
  assign rw_fall      = stb_q2[STB_RW] & ~stb_q1[STB_RW];
  assign strobes_idle = stb_q1[STB_RD] & stb_q2[STB_RD] & stb_q1[STB_WR] & stb_q2[STB_WR];

  // input word sampled alongside the strobes so it lines up with wr_rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= din;
  end

  sfifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rd_fall(rd_fall), .rd_rise(rd_rise), .wr_fall(wr_fall), .wr_rise(wr_rise),
    .rw_fall(rw_fall), .strobes_idle(strobes_idle),
    .rd_en(rd_en), .wr_en(wr_en), .rew_go(rew_go),
    .rptr(rptr), .wptr(wptr), .occ(occ), .dout_vld(dout_vld), .err(err)
  );

  sfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk(clk), .wr_en(wr_en), .waddr(wptr), .wdata(din_q),
    .rd_en(rd_en), .raddr(rptr), .rdata(rdata)
  );

  assign dout    = dout_vld ? rdata : '0;
  assign empty_n = (occ != '0);
  assign full_n  = (occ != CW'(DEPTH));
endmodule

// File: rtl/sfifo_strobe_chk.sv
module sfifo_strobe_chk #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int CW    = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          empty_n,
  input logic          full_n,
  input logic          err,
  input logic          dout_vld,
  input logic          rd_fall,
  input logic          wr_rise,
  input logic          rew_go,
  input logic [AW-1:0] rptr,
  input logic [CW-1:0] occ
);
  p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));

  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !rd_fall) |=> !full_n);

  p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !wr_rise && !rew_go) |=> !empty_n);

  p_vld_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_vld) |-> $past(rd_fall));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_rewind_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rew_go |=> (rptr == '0));
endmodule

bind sfifo_strobe sfifo_strobe_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .empty_n(empty_n), .full_n(full_n), .err(err),
  .dout_vld(dout_vld), .rd_fall(rd_fall), .wr_rise(wr_rise), .rew_go(rew_go),
  .rptr(rptr), .occ(occ)
);

// File: tb/sfifo_strobe_tb.sv
module sfifo_strobe_tb;
  localparam int DEPTH = 512;
  localparam int WIDTH = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_n = 1'b1, wr_n = 1'b1, rewind_n = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic             dout_vld, empty_n, full_n, err;
  int               total = 0, bad = 0;

  always #4 clk = ~clk;

  sfifo_strobe #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .rewind_n(rewind_n),
    .din(din), .dout(dout), .dout_vld(dout_vld), .empty_n(empty_n),
    .full_n(full_n), .err(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; rewind_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_word(input logic [WIDTH-1:0] d);
    @(negedge clk);
    din = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_word(output logic [WIDTH-1:0] d, output logic v);
    @(negedge clk);
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    d = dout; v = dout_vld;
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rewind_pulse();
    @(negedge clk);
    rewind_n = 1'b0;
    repeat (3) @(negedge clk);
    rewind_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 empty_n", empty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 dout_vld", dout_vld, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_order();
    logic [WIDTH-1:0] w [4] = '{9'h1A5, 9'h05A, 9'h100, 9'h0FF};
    logic [WIDTH-1:0] d;
    logic v;
    do_reset();
    wr_word(w[0]);
    chk("R4 empty_n after write", empty_n, 1);
    for (int i = 1; i < 4; i++) wr_word(w[i]);
    for (int i = 0; i < 4; i++) begin
      rd_word(d, v);
      chk("R2 order", d, w[i]);
      chk("R11 vld during read", v, 1);
      chk("R11 vld after release", dout_vld, 0);
    end
    chk("R4 empty_n after drain", empty_n, 0);
    chk("R12 err clear", err, 0);
  endtask

  task automatic t_capture();
    logic [WIDTH-1:0] d;
    logic v;
    do_reset();
    @(negedge clk);
    din = 9'h0C3; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    din = 9'h13C;
    @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_word(d, v);
    chk("R3 capture at rising wr_n", d, 9'h13C);
  endtask

  task automatic t_underflow();
    logic [WIDTH-1:0] d;
    logic v;
    do_reset();
    rd_word(d, v);
    chk("R6 vld on empty read", v, 0);
    chk("R6 err", err, 1);
    wr_word(9'h033);
    rd_word(d, v);
    chk("R6 pointers unmoved", d, 9'h033);
    chk("R12 err sticky", err, 1);
  endtask

  task automatic t_full();
    logic [WIDTH-1:0] d;
    logic v;
    do_reset();
    for (int i = 0; i < DEPTH; i++) wr_word(WIDTH'(i ^ 9'h0AA));
    chk("R5 full_n", full_n, 0);
    chk("R4 empty_n when full", empty_n, 1);
    chk("R5 no err yet", err, 0);
    wr_word(9'h1FF);
    chk("R5 err on full write", err, 1);
    chk("R5 still full", full_n, 0);
    rd_word(d, v);
    chk("R5 first word", d, 9'h0AA);
    chk("R7 full_n after read", full_n, 1);
    for (int i = 1; i < DEPTH; i++) begin
      rd_word(d, v);
      if (d !== WIDTH'(i ^ 9'h0AA)) chk("R5 content", d, WIDTH'(i ^ 9'h0AA));
    end
    chk("R5 empty after readout", empty_n, 0);
  endtask

  task automatic t_rewind();
    logic [WIDTH-1:0] d;
    logic v;
    do_reset();
    for (int i = 0; i < 3; i++) wr_word(WIDTH'(9'h010 + i));
    rd_word(d, v);
    rd_word(d, v);
    rewind_pulse();
    chk("R8 no err", err, 0);
    for (int i = 0; i < 3; i++) begin
      rd_word(d, v);
      chk("R8 replay", d, 9'h010 + i);
    end
    wr_word(9'h099);
    rd_word(d, v);
    chk("R8 write pointer kept", d, 9'h099);
    chk("R8 empty after", empty_n, 0);
  endtask

  task automatic t_rew_busy();
    logic [WIDTH-1:0] d;
    logic v;
    do_reset();
    for (int i = 0; i < 3; i++) wr_word(WIDTH'(9'h020 + i));
    rd_word(d, v);
    @(negedge clk);
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 read during hold", dout, 9'h021);
    rewind_n = 1'b0;
    repeat (3) @(negedge clk);
    rewind_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 err", err, 1);
    rd_word(d, v);
    chk("R9 order kept", d, 9'h022);
  endtask

  task automatic t_rew_late();
    logic [WIDTH-1:0] d;
    logic v;
    do_reset();
    for (int i = 0; i < DEPTH; i++) wr_word(WIDTH'(i));
    rd_word(d, v);
    rd_word(d, v);
    chk("R10 no err before", err, 0);
    rewind_pulse();
    chk("R10 err", err, 1);
    rd_word(d, v);
    chk("R10 order kept", d, 2);
  endtask

  initial begin
    t_reset();
    t_order();
    t_capture();
    t_underflow();
    t_full();
    t_rewind();
    t_rew_busy();
    t_rew_late();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule